// File: doc/BRIEF.md
# Zero-overhead hardware loop controller

This block sits next to a processor's fetch unit and runs counted loops without a branch instruction at the bottom of the body. It holds three registers: the address of the first body instruction, the loop end address and the number of iterations left. A loop-setup command fills all three at once. The three registers can also be written through a small special-register port, and all three are always visible on readback outputs.

On every retired instruction, the fetch unit supplies the sequential next PC and says whether a taken jump or branch is leaving the sequential path. When the sequential successor equals the loop end and iterations remain, the block pulses a redirect in the same cycle toward the loop begin and decrements the count. The setup command has two guarded variants. Each one skips the whole body by redirecting to the new loop end when the operand rules out any iteration.

Internally, one decision process picks a single action each cycle from the enumerated set IDLE, SETUP_ENTER, SETUP_SKIP, LOOP_BACK and FALL_THRU. The priority is setup command, then loop-end match, then nothing. These are the block's transitions:
- A setup command goes to SETUP_ENTER or SETUP_SKIP.
- A retire at the loop end goes to LOOP_BACK when the count is nonzero, otherwise to FALL_THRU.
- Every other cycle is IDLE.

A register process applies the chosen action. An output process drives the redirect from it.

Top module: `hwl_ctrl`

## Requirements
- R1: After reset the loop begin, loop end and loop count readbacks are all zero and no redirect is signalled.
- R2: A special-register write with address 0 loads loop begin, address 1 loads loop end and address 2 loads loop count, visible on readback from the next cycle. Address 3 changes no register.
- R3: A setup command loads loop end with setup PC plus the zero-extended 8-bit offset plus 4. It loads loop begin with the supplied address of the instruction after the setup instruction.
- R4: A setup command loads the loop count with the operand minus one, modulo 2^32. A special-register write in the same cycle is discarded.
- R5: The setup kind is encoded 0 = plain, 1 = not-equal-zero, 2 = greater-than-zero, 3 = plain. Plain never redirects. Not-equal-zero redirects to the new loop end, in the setup cycle, when the operand is zero. Greater-than-zero does the same when the operand is zero or negative as a signed value.
- R6: A retire that is not taken, whose next PC equals loop end and with a nonzero count, raises the redirect in that same cycle toward loop begin. The count then drops by one.
- R7: Such a retire with a count of zero produces no redirect and leaves the count at zero.
- R8: While the exception-mode input is high, or the loop-enable input is low, a retire at the loop end produces no redirect and leaves the count unchanged.
- R9: A retire marked taken produces no loop-back redirect and leaves the count unchanged, even when its next PC equals loop end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loop_en | input | 1 | Loop feature enable |
| exc_mode | input | 1 | Exception mode, suppresses loop-back |
| setup_valid | input | 1 | Loop-setup command strobe |
| setup_kind | input | 2 | Setup variant (0 plain, 1 not-equal-zero, 2 greater-than-zero) |
| setup_pc | input | 32 | PC of the setup instruction |
| setup_next_pc | input | 32 | Address of the instruction after the setup |
| setup_off | input | 8 | Unsigned loop-end offset |
| setup_opnd | input | 32 | Iteration operand |
| sr_we | input | 1 | Special-register write strobe |
| sr_addr | input | 2 | Special-register number |
| sr_wdata | input | 32 | Special-register write data |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_taken | input | 1 | The retiring instruction takes a jump or branch |
| retire_next_pc | input | 32 | Sequential next PC of the retiring instruction |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_addr | output | 32 | Fetch redirect target |
| rd_begin | output | 32 | Loop begin readback |
| rd_end | output | 32 | Loop end readback |
| rd_count | output | 32 | Loop count readback |

## Verification
The hardest case to reach is the end of a multi-iteration loop. The count must pass through each value, and the final retire at the loop end must fall through with no redirect. The bench issues a setup with operand 3 and then repeats retires whose next PC matches the computed loop end, checking the redirect and the count after each one. A setup with operand 1 shows a single pass through the body. Exception mode, a disabled feature and a taken branch are each tried with a nonzero count, so that a wrongly allowed loop-back would show up in the count readback.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
    typedef enum logic [1:0] {
        KIND_PLAIN = 2'd0,
        KIND_NEZ   = 2'd1,
        KIND_GTZ   = 2'd2,
        KIND_ALT   = 2'd3
    } setup_kind_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_SETUP_ENTER,
        ACT_SETUP_SKIP,
        ACT_LOOP_BACK,
        ACT_FALL_THRU
    } act_e;

    localparam logic [1:0] SR_BEGIN = 2'd0;
    localparam logic [1:0] SR_END   = 2'd1;
    localparam logic [1:0] SR_COUNT = 2'd2;
endpackage

// File: rtl/hwl_setup_calc.sv
module hwl_setup_calc
    import hwl_pkg::*;
#(
    parameter int AW   = 32,
    parameter int OFFW = 8,
    parameter int CW   = 32,
    parameter int ILEN = 4
) (
    input  logic [AW-1:0]   pc,
    input  logic [OFFW-1:0] off,
    input  logic [1:0]      kind,
    input  logic [CW-1:0]   opnd,
    output logic [AW-1:0]   end_addr,
    output logic [CW-1:0]   count_init,
    output logic            skip
);
    localparam logic [AW-1:0] STEP = AW'(ILEN);

    logic opnd_zero;
    logic opnd_neg;

    assign opnd_zero  = (opnd == '0);
    assign opnd_neg   = opnd[CW-1];
    assign end_addr   = pc + {{(AW-OFFW){1'b0}}, off} + STEP;
    assign count_init = opnd - CW'(1);

    always_comb begin
        unique case (setup_kind_e'(kind))
            KIND_NEZ: skip = opnd_zero;
            KIND_GTZ: skip = opnd_zero | opnd_neg;
            default:  skip = 1'b0;
        endcase
    end
endmodule

// File: rtl/hwl_end_detect.sv
module hwl_end_detect #(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input  logic          retire_valid,
    input  logic          retire_taken,
    input  logic [AW-1:0] next_pc,
    input  logic [AW-1:0] loop_end,
    input  logic [CW-1:0] count,
    input  logic          loop_en,
    input  logic          exc_mode,
    output logic          at_end,
    output logic          go_back
);
    assign at_end  = retire_valid & ~retire_taken & loop_en & ~exc_mode
                   & (next_pc == loop_end);
    assign go_back = at_end & (count != '0);
endmodule

// File: rtl/hwl_ctrl.sv
module hwl_ctrl
    import hwl_pkg::*;
#(
    parameter int AW   = 32,
    parameter int OFFW = 8,
    parameter int CW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            loop_en,
    input  logic            exc_mode,
    input  logic            setup_valid,
    input  logic [1:0]      setup_kind,
    input  logic [AW-1:0]   setup_pc,
    input  logic [AW-1:0]   setup_next_pc,
    input  logic [OFFW-1:0] setup_off,
    input  logic [CW-1:0]   setup_opnd,
    input  logic            sr_we,
    input  logic [1:0]      sr_addr,
    input  logic [AW-1:0]   sr_wdata,
    input  logic            retire_valid,
    input  logic            retire_taken,
    input  logic [AW-1:0]   retire_next_pc,
    output logic            redir_valid,
    output logic [AW-1:0]   redir_addr,
    output logic [AW-1:0]   rd_begin,
    output logic [AW-1:0]   rd_end,
    output logic [CW-1:0]   rd_count
);
    logic [AW-1:0] lbeg_q, lend_q;
    logic [CW-1:0] lcnt_q;
    logic [AW-1:0] new_end;
    logic [CW-1:0] new_count;
    logic          skip;
    logic          at_end, go_back;
    act_e          act;

    hwl_setup_calc #(.AW(AW), .OFFW(OFFW), .CW(CW)) u_calc (
        .pc(setup_pc), .off(setup_off), .kind(setup_kind), .opnd(setup_opnd),
        .end_addr(new_end), .count_init(new_count), .skip(skip)
    );

    hwl_end_detect #(.AW(AW), .CW(CW)) u_det (
        .retire_valid(retire_valid), .retire_taken(retire_taken),
        .next_pc(retire_next_pc), .loop_end(lend_q), .count(lcnt_q),
        .loop_en(loop_en), .exc_mode(exc_mode),
        .at_end(at_end), .go_back(go_back)
    );

    // action decision: setup beats loop-end match
    always_comb begin
        if (setup_valid)  act = skip ? ACT_SETUP_SKIP : ACT_SETUP_ENTER;
        else if (go_back) act = ACT_LOOP_BACK;
        else if (at_end)  act = ACT_FALL_THRU;
        else              act = ACT_IDLE;
    end

    // register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lbeg_q <= '0;
            lend_q <= '0;
            lcnt_q <= '0;
        end else begin
            unique case (act)
                ACT_SETUP_ENTER, ACT_SETUP_SKIP: begin
                    lbeg_q <= setup_next_pc;
                    lend_q <= new_end;
                    lcnt_q <= new_count;
                end
                ACT_LOOP_BACK: lcnt_q <= lcnt_q - CW'(1);
                ACT_FALL_THRU, ACT_IDLE: ;
                default: ;
            endcase
            if (sr_we && !setup_valid) begin
                unique case (sr_addr)
                    SR_BEGIN: lbeg_q <= sr_wdata;
                    SR_END:   lend_q <= sr_wdata;
                    SR_COUNT: lcnt_q <= CW'(sr_wdata);
                    default:  ;
                endcase
            end
        end
    end

    // output process
    always_comb begin
        redir_valid = 1'b0;
        redir_addr  = '0;
        unique case (act)
            ACT_SETUP_SKIP: begin
                redir_valid = 1'b1;
                redir_addr  = new_end;
            end
            ACT_LOOP_BACK: begin
                redir_valid = 1'b1;
                redir_addr  = lbeg_q;
            end
            ACT_IDLE, ACT_SETUP_ENTER, ACT_FALL_THRU: ;
            default: ;
        endcase
    end

    assign rd_begin = lbeg_q;
    assign rd_end   = lend_q;
    assign rd_count = lcnt_q;

    AST_EXC_NO_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_mode && !setup_valid) |-> !redir_valid); // R8
    AST_TAKEN_NO_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_taken && !setup_valid) |-> !redir_valid); // R9
    AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && !setup_valid && !(sr_we && sr_addr == SR_COUNT))
        |=> rd_count == $past(rd_count) - CW'(1)); // R6
    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_count == '0 && !setup_valid && !sr_we) |=> rd_count == '0); // R7
    AST_SETUP_END: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid |=> rd_end == $past(setup_pc) + AW'($past(setup_off)) + AW'(4)); // R3
    AST_PLAIN_NO_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_valid && setup_kind[1] == setup_kind[0]) |-> !redir_valid); // R5
endmodule

// File: tb/tb_hwl_ctrl.sv
`timescale 1ns/1ps
module tb_hwl_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        loop_en, exc_mode;
    logic        setup_valid;
    logic [1:0]  setup_kind;
    logic [31:0] setup_pc, setup_next_pc, setup_opnd;
    logic [7:0]  setup_off;
    logic        sr_we;
    logic [1:0]  sr_addr;
    logic [31:0] sr_wdata;
    logic        retire_valid, retire_taken;
    logic [31:0] retire_next_pc;
    logic        redir_valid;
    logic [31:0] redir_addr, rd_begin, rd_end, rd_count;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hwl_ctrl dut (
        .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .exc_mode(exc_mode),
        .setup_valid(setup_valid), .setup_kind(setup_kind), .setup_pc(setup_pc),
        .setup_next_pc(setup_next_pc), .setup_off(setup_off), .setup_opnd(setup_opnd),
        .sr_we(sr_we), .sr_addr(sr_addr), .sr_wdata(sr_wdata),
        .retire_valid(retire_valid), .retire_taken(retire_taken),
        .retire_next_pc(retire_next_pc), .redir_valid(redir_valid),
        .redir_addr(redir_addr), .rd_begin(rd_begin), .rd_end(rd_end),
        .rd_count(rd_count)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        setup_valid = 0; setup_kind = 0; setup_pc = 0; setup_next_pc = 0;
        setup_off = 0; setup_opnd = 0; sr_we = 0; sr_addr = 0; sr_wdata = 0;
        retire_valid = 0; retire_taken = 0; retire_next_pc = 0;
    endtask

    // inputs are applied right after a falling edge; combinational outputs
    // are checked 2 ns later; registers are checked at the next falling edge
    task automatic do_setup(input logic [1:0] kind, input logic [31:0] pc,
                            input logic [31:0] nxt, input logic [7:0] off,
                            input logic [31:0] opnd, input logic exp_rv,
                            input logic [31:0] exp_ra, input string tag);
        setup_valid = 1; setup_kind = kind; setup_pc = pc;
        setup_next_pc = nxt; setup_off = off; setup_opnd = opnd;
        #2;
        chk({tag, " redir_valid"}, 32'(redir_valid), 32'(exp_rv));
        if (exp_rv) chk({tag, " redir_addr"}, redir_addr, exp_ra);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_retire(input logic [31:0] npc, input logic taken,
                             input logic exp_rv, input logic [31:0] exp_ra,
                             input string tag);
        retire_valid = 1; retire_taken = taken; retire_next_pc = npc;
        #2;
        chk({tag, " redir_valid"}, 32'(redir_valid), 32'(exp_rv));
        if (exp_rv) chk({tag, " redir_addr"}, redir_addr, exp_ra);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_srw(input logic [1:0] a, input logic [31:0] d);
        sr_we = 1; sr_addr = a; sr_wdata = d;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset();
        chk("R1 begin", rd_begin, 0);
        chk("R1 end", rd_end, 0);
        chk("R1 count", rd_count, 0);
        chk("R1 redir", 32'(redir_valid), 0);
    endtask

    task automatic t_srwrite();
        do_srw(2'd0, 32'h0000_0200);
        do_srw(2'd1, 32'h0000_0240);
        do_srw(2'd2, 32'h0000_0007);
        chk("R2 begin", rd_begin, 32'h200);
        chk("R2 end", rd_end, 32'h240);
        chk("R2 count", rd_count, 32'h7);
        do_srw(2'd3, 32'hDEAD_BEEF);
        chk("R2 addr3 begin", rd_begin, 32'h200);
        chk("R2 addr3 end", rd_end, 32'h240);
        chk("R2 addr3 count", rd_count, 32'h7);
    endtask

    task automatic t_loop_iter();
        do_setup(2'd0, 32'h100, 32'h103, 8'h10, 32'd3, 0, 0, "R5 plain enter");
        chk("R3 end", rd_end, 32'h114);
        chk("R3 begin", rd_begin, 32'h103);
        chk("R4 count", rd_count, 32'd2);
        do_retire(32'h110, 0, 0, 0, "R6 mid body");
        do_retire(32'h114, 0, 1, 32'h103, "R6 back1");
        chk("R6 count1", rd_count, 32'd1);
        do_retire(32'h114, 0, 1, 32'h103, "R6 back2");
        chk("R6 count0", rd_count, 32'd0);
        do_retire(32'h114, 0, 0, 0, "R7 fall");
        chk("R7 count", rd_count, 32'd0);
    endtask

    task automatic t_once();
        do_setup(2'd3, 32'h400, 32'h402, 8'hFF, 32'd1, 0, 0, "R5 kind3 enter");
        chk("R3 end zext", rd_end, 32'h503);
        chk("R4 count once", rd_count, 32'd0);
        do_retire(32'h503, 0, 0, 0, "R7 single pass");
    endtask

    task automatic t_nez();
        do_setup(2'd1, 32'h600, 32'h603, 8'h20, 32'd0, 1, 32'h624, "R5 nez zero");
        chk("R4 count wrap", rd_count, 32'hFFFF_FFFF);
        do_setup(2'd1, 32'h600, 32'h603, 8'h20, 32'd5, 0, 0, "R5 nez five");
    endtask

    task automatic t_gtz();
        do_setup(2'd2, 32'h700, 32'h703, 8'h08, 32'hFFFF_FFFE, 1, 32'h70C, "R5 gtz neg");
        do_setup(2'd2, 32'h700, 32'h703, 8'h08, 32'd0, 1, 32'h70C, "R5 gtz zero");
        do_setup(2'd2, 32'h700, 32'h703, 8'h08, 32'd4, 0, 0, "R5 gtz pos");
        chk("R4 count gtz", rd_count, 32'd3);
    endtask

    task automatic t_suppress();
        // count is 3, end is 0x70C
        exc_mode = 1;
        do_retire(32'h70C, 0, 0, 0, "R8 exc");
        exc_mode = 0;
        chk("R8 exc count", rd_count, 32'd3);
        loop_en = 0;
        do_retire(32'h70C, 0, 0, 0, "R8 disabled");
        loop_en = 1;
        chk("R8 dis count", rd_count, 32'd3);
        do_retire(32'h70C, 1, 0, 0, "R9 taken");
        chk("R9 count", rd_count, 32'd3);
    endtask

    task automatic t_conflict();
        sr_we = 1; sr_addr = 2'd2; sr_wdata = 32'h55;
        do_setup(2'd0, 32'h800, 32'h803, 8'h00, 32'd9, 0, 0, "R4 conflict");
        chk("R4 conflict count", rd_count, 32'd8);
        chk("R3 offset zero end", rd_end, 32'h804);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        loop_en = 1; exc_mode = 0;
        rst_n = 0;
        #1;
        t_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_srwrite();
        t_loop_iter();
        t_once();
        t_nez();
        t_gtz();
        t_suppress();
        t_conflict();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule